// File: doc/BRIEF.md
# Parking Bus Arbiter with Priority Classes

This block decides which of several bus masters owns a shared bus. Every master has a private request line into the arbiter and receives a private grant line back. The arbiter keeps exactly one owner at a time. A subset of masters, fixed by a parameter mask, forms an urgent class that always wins over the ordinary class. Inside each class a rotating pointer shares the bus evenly, so no master is starved.

Arbitration overlaps with bus traffic. On every clock edge the arbiter registers a candidate for the next owner while the present owner is still marked busy. On the first edge where busy is low, that candidate takes over at once, with no idle cycle between owners. When nobody else asks for the bus, the present owner stays parked on it. It can then start further transactions with no new arbitration. A parked owner gives the bus up at the end of its current transaction once another master requests.

Top module: `arb_park_top`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: While `rst_n` is low, `grant` is all zeros after the next edge; there is then no owner and both class pointers sit at position 0.
- R3: A master whose bit is set in `HI_MASK` is always chosen as candidate ahead of any master outside the mask, whatever the pointers hold.
- R4: Inside a class the candidate is the first requesting member at or after that class's pointer, counting upward by master index and wrapping; the current owner is not a contender. After each owner change, the new owner's class pointer moves to the position one above the new owner's index, modulo the master count.
- R5: When no master other than the owner requests, `grant` keeps its value, even if the owner drops its own request.
- R6: `grant` never changes on a clock edge at which `busy` is sampled high.
- R7: The candidate register is loaded on every edge from the requests sampled at that edge. On the first edge with `busy` low whose registered candidate differs from the owner, `grant` switches to that candidate. Once `grant` is non-zero it never returns to zero. From an idle, ownerless arbiter, a lone request seen at one edge is granted at the next.
- R8: A parked owner whose bus is idle loses the grant to a waiting master two edges after the edge at which it became owner, if that master was requesting throughout.
- R9: A master that newly receives a grant had its request high at the edge two edges before the grant became visible.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NUM_MASTERS | One request line per master |
| busy | input | 1 | High while the current owner's transaction is in progress |
| grant | output | NUM_MASTERS | One grant line per master, at most one bit high |

## Verification
The assertions assume that a master keeps its request high until it sees its own grant. They also assume that `busy` is raised only while some grant is active, since the owner is the only master that can run a transaction. The parking and grant-origin properties depend on these rules, because the candidate is built from requests one edge old. The random stimulus lets an idle master raise its request at will, and it never lowers a waiting request. Only the owner may lower its request, and busy is driven only while a grant is present.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Class encoding used for the per-class round-robin pointers.
  typedef enum logic {
    CLS_NORMAL = 1'b0,
    CLS_URGENT = 1'b1
  } arb_class_e;

  // Position one above idx, wrapping at n.
  function automatic int unsigned next_pos(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Number of bits needed to index n entries, never less than one.
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
// Round-robin picker for one class: first eligible master at or above the
// pointer, otherwise the lowest eligible master overall.
module arb_rr_pick #(
  parameter int unsigned N   = 6,
  parameter int unsigned IDW = 3
) (
  input  logic [N-1:0]   elig,
  input  logic [IDW-1:0] ptr,
  output logic           hit,
  output logic [IDW-1:0] idx
);

  // Lowest set bit of a vector, searched top-down so the last write wins.
  function automatic logic [IDW-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDW'(i);
    end
    return r;
  endfunction

  // Bits strictly below the pointer.
  function automatic logic [N-1:0] below_mask(input logic [IDW-1:0] p);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) begin
      m[i] = (i < int'(p));
    end
    return m;
  endfunction

  logic [N-1:0] upper;

  always_comb begin
    upper = elig & ~below_mask(ptr);
    hit   = |elig;
    if (|upper) idx = lowest_set(upper);
    else        idx = lowest_set(elig);
  end

endmodule

// File: rtl/arb_select.sv
// Candidate selection: urgent class first, then normal class, then park.
module arb_select #(
  parameter int unsigned N       = 6,
  parameter int unsigned IDW     = 3,
  parameter logic [N-1:0] HI_MASK = '0
) (
  input  logic [N-1:0]   req,
  input  logic           owner_v,
  input  logic [IDW-1:0] owner_idx,
  input  logic [IDW-1:0] ptr_lo,
  input  logic [IDW-1:0] ptr_hi,
  output logic           cand_v,
  output logic [IDW-1:0] cand_idx,
  output logic           cand_hi
);
  import arb_pkg::*;

  logic [N-1:0]   owner_oh;
  logic [N-1:0]   contend;
  logic [1:0]     cls_hit;
  logic [IDW-1:0] cls_idx [2];

  always_comb begin
    owner_oh = owner_v ? (N'(1) << owner_idx) : '0;
    contend  = req & ~owner_oh;
  end

  // One picker per class; the class mask and pointer are chosen per slot.
  for (genvar g = 0; g < 2; g++) begin : g_cls
    localparam logic [N-1:0] CLS_MASK = (g == int'(CLS_URGENT)) ? HI_MASK : ~HI_MASK;
    logic [IDW-1:0] cls_ptr;
    assign cls_ptr = (g == int'(CLS_URGENT)) ? ptr_hi : ptr_lo;
    arb_rr_pick #(.N(N), .IDW(IDW)) u_pick (
      .elig (contend & CLS_MASK),
      .ptr  (cls_ptr),
      .hit  (cls_hit[g]),
      .idx  (cls_idx[g])
    );
  end

  always_comb begin
    cand_v   = 1'b0;
    cand_idx = '0;
    cand_hi  = 1'b0;
    if (cls_hit[CLS_URGENT]) begin
      cand_v   = 1'b1;
      cand_idx = cls_idx[CLS_URGENT];
      cand_hi  = 1'b1;
    end else if (cls_hit[CLS_NORMAL]) begin
      cand_v   = 1'b1;
      cand_idx = cls_idx[CLS_NORMAL];
      cand_hi  = 1'b0;
    end else if (owner_v) begin
      // Nobody else wants the bus: stay parked on the owner.
      cand_v   = 1'b1;
      cand_idx = owner_idx;
      cand_hi  = HI_MASK[owner_idx];
    end
  end

endmodule

// File: rtl/arb_state.sv
// Candidate pipeline register, owner register and class pointers.
module arb_state #(
  parameter int unsigned N   = 6,
  parameter int unsigned IDW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy,
  input  logic           cand_v,
  input  logic [IDW-1:0] cand_idx,
  input  logic           cand_hi,
  output logic           owner_v,
  output logic [IDW-1:0] owner_idx,
  output logic [IDW-1:0] ptr_lo,
  output logic [IDW-1:0] ptr_hi,
  output logic           handover
);
  import arb_pkg::*;

  logic           nxt_v;
  logic [IDW-1:0] nxt_idx;
  logic           nxt_hi;
  logic [IDW-1:0] nxt_after;

  always_comb begin
    handover  = !busy && nxt_v && (!owner_v || (nxt_idx != owner_idx));
    nxt_after = IDW'(next_pos(int'(nxt_idx), N));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_v     <= 1'b0;
      nxt_idx   <= '0;
      nxt_hi    <= 1'b0;
      owner_v   <= 1'b0;
      owner_idx <= '0;
      ptr_lo    <= '0;
      ptr_hi    <= '0;
    end else begin
      nxt_v   <= cand_v;
      nxt_idx <= cand_idx;
      nxt_hi  <= cand_hi;
      if (handover) begin
        owner_v   <= 1'b1;
        owner_idx <= nxt_idx;
        if (nxt_hi) ptr_hi <= nxt_after;
        else        ptr_lo <= nxt_after;
      end
    end
  end

endmodule

// File: rtl/arb_park_top.sv
module arb_park_top #(
  parameter int unsigned NUM_MASTERS = 6,
  parameter logic [NUM_MASTERS-1:0] HI_MASK = 6'b000011
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   busy,
  output logic [NUM_MASTERS-1:0] grant
);
  import arb_pkg::*;

  localparam int unsigned IDW = idx_bits(NUM_MASTERS);

  logic           owner_v;
  logic [IDW-1:0] owner_idx;
  logic [IDW-1:0] ptr_lo;
  logic [IDW-1:0] ptr_hi;
  logic           cand_v;
  logic [IDW-1:0] cand_idx;
  logic           cand_hi;
  logic           handover_w;

  arb_select #(.N(NUM_MASTERS), .IDW(IDW), .HI_MASK(HI_MASK)) u_sel (
    .req       (req),
    .owner_v   (owner_v),
    .owner_idx (owner_idx),
    .ptr_lo    (ptr_lo),
    .ptr_hi    (ptr_hi),
    .cand_v    (cand_v),
    .cand_idx  (cand_idx),
    .cand_hi   (cand_hi)
  );

  arb_state #(.N(NUM_MASTERS), .IDW(IDW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cand_v    (cand_v),
    .cand_idx  (cand_idx),
    .cand_hi   (cand_hi),
    .owner_v   (owner_v),
    .owner_idx (owner_idx),
    .ptr_lo    (ptr_lo),
    .ptr_hi    (ptr_hi),
    .handover  (handover_w)
  );

  always_comb begin
    grant = owner_v ? (NUM_MASTERS'(1) << owner_idx) : '0;
  end

endmodule

// File: rtl/arb_park_chk.sv
module arb_park_chk #(
  parameter int unsigned N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         busy,
  input logic [N-1:0] grant,
  input logic         handover
);

  assert_onehot_grant_R1: assert property (@(posedge clk) $onehot0(grant));

  assert_reset_clear_R2: assert property (@(posedge clk) !rst_n |=> (grant == '0));

  assert_park_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((req & ~grant) == '0) && ($past(req & ~grant) == '0))
      |=> $stable(grant));

  assert_busy_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(grant));

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> (grant != '0));

  assert_handover_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    handover |=> !$stable(grant));

  assert_grant_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~$past(grant)) != '0) |-> (((grant & ~$past(grant)) & $past(req, 2)) != '0));

endmodule

bind arb_park_top arb_park_chk #(.N(NUM_MASTERS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .busy     (busy),
  .grant    (grant),
  .handover (handover_w)
);

// File: tb/sim_arb_park_top.sv
module sim_arb_park_top;
  localparam int N = 6;
  localparam logic [N-1:0] HI = 6'b000011;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         busy = 1'b0;
  logic [N-1:0] grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  arb_park_top #(.NUM_MASTERS(N), .HI_MASK(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .grant(grant)
  );

  // Reference state, rebuilt from the requirements.
  int m_own, m_nidx, m_phi, m_plo;
  bit m_nv, m_nhi;

  // Scan one class by offset from its pointer; returns -1 when empty.
  function automatic int scan_class(logic [N-1:0] r, int own, int ptr, bit urgent);
    for (int k = 0; k < N; k++) begin
      int i;
      i = (ptr + k) % N;
      if (r[i] && i != own && (HI[i] == urgent)) return i;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = -1; m_nv = 0; m_nidx = 0; m_nhi = 0; m_phi = 0; m_plo = 0;
    end else begin
      int c; bit cv; bit chi;
      c = scan_class(req, m_own, m_phi, 1'b1); chi = 1'b1;
      if (c < 0) begin c = scan_class(req, m_own, m_plo, 1'b0); chi = 1'b0; end
      if (c < 0 && m_own >= 0) begin c = m_own; chi = HI[m_own]; end
      cv = (c >= 0);
      if (!busy && m_nv && m_own != m_nidx) begin
        m_own = m_nidx;
        if (m_nhi) m_phi = (m_nidx + 1) % N;
        else       m_plo = (m_nidx + 1) % N;
      end
      m_nv = cv; m_nidx = cv ? c : 0; m_nhi = chi;
    end
  end

  function automatic logic [N-1:0] model_grant();
    return (m_own < 0) ? '0 : (N'(1) << m_own);
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Continuous comparison against the reference (R3 R4 R5 R8 coverage).
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R3 R4 R5 R8 reference", grant, model_grant());
      checks++;
      if (!$onehot0(grant)) begin
        errors++;
        $display("FAIL R1 actual=%b expected=at most one bit", grant);
      end
    end
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1314));
    model_on = 1'b1;
    edges(4);
    chk("R2 reset", grant, '0);
    rst_n = 1'b1;
    // Lone request from idle: granted one edge after it is sampled (R7).
    req = 6'b001000;
    edges(2);
    chk("R7 first grant", grant, 6'b001000);
    // Parking after the owner drops its request (R5).
    req = '0;
    edges(5);
    chk("R5 parked", grant, 6'b001000);
    // Busy freezes the grant (R6), urgent master wins at release (R3).
    busy = 1'b1;
    req  = 6'b010001;
    edges(4);
    chk("R6 busy hold", grant, 6'b001000);
    busy = 1'b0;
    edges(1);
    chk("R3 urgent first", grant, 6'b000001);
    // Parked urgent owner yields to waiting master 4 (R8).
    req = 6'b010000;
    edges(2);
    chk("R8 yield", grant, 6'b010000);
    // Rotation in the normal class from pointer 5 (R4).
    req = 6'b101100;
    edges(2);
    chk("R4 rotate a", grant, 6'b100000);
    edges(2);
    chk("R4 rotate b", grant, 6'b000100);
    edges(2);
    chk("R4 rotate c", grant, 6'b001000);
    // Random phase: waiting masters hold requests, owner may release.
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [N-1:0] r;
      r = req;
      for (int i = 0; i < N; i++) begin
        if (!r[i]) begin
          if ($urandom % 4 == 0) r[i] = 1'b1;
        end else if (grant[i]) begin
          if ($urandom % 3 == 0) r[i] = 1'b0;
        end
      end
      req  = r;
      busy = (grant != '0) && ($urandom % 2 == 0);
      @(negedge clk);
    end
    // Reset mid-run clears the grant (R2).
    rst_n = 1'b0;
    busy  = 1'b0;
    edges(2);
    chk("R2 reset again", grant, '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule